// File: doc/BRIEF.md
# Mailbox Memory Writer with Running CRC-16

This block lets a management host fill an on-chip processor memory one 32-bit word at a time through six 16-bit mailbox registers. The host sets a word-aligned target address split over two registers and stages a data word split over two more. Each write of the execute-plus-write pattern to the command register stores the staged word at the current address and moves the address on by one word. The host therefore sets the address once and then streams data words.

Every stored word is also folded into a running CRC-16 (polynomial 0x1021, initial value 0, no reflection, no final XOR), one byte per cycle, most-significant byte first. When the load is done, the host reads the check value back and compares it with the CRC it computed itself. A control state machine has two states. `IDLE` waits for commands. `FOLD` lasts four cycles, one per byte, and busy is reported throughout. The transition `IDLE -> FOLD` (launch) fires on an accepted store command. The transition `FOLD -> FOLD` (next byte) steps the byte counter. The transition `FOLD -> IDLE` (done) fires after the fourth byte.

The host port is a plain address/data port sampled on the clock: a write strobe, an address, write data, and read data decoded combinationally from the address. Stored words leave the block through a one-cycle memory write strobe with a byte address and a 32-bit data word.

Top module: `mbox_crc_writer`

## Requirements
- R1: After reset the CRC register, both address registers and the busy bit read 0, and the memory write strobe is low.
- R2: The registers decode at command 0x0200, CRC 0x0201, address high 0x0202, address low 0x0203, data high 0x0204 and data low 0x0205. The address and data registers read back what was written. Any other address reads 0 and ignores writes.
- R3: The address low register keeps only bits 15:2, and its bits 1:0 always read 0.
- R4: A command write with bit 15 (execute) and bit 14 (write) set, accepted while not busy, raises the memory write strobe for exactly one cycle, starting one cycle after the command. That cycle carries byte address {high, low} and data {data high, data low}, with data high forming bits 31:16.
- R5: After each stored word the 32-bit byte address advances by 4, carrying from the low register into the high register.
- R6: Each stored word updates the CRC with its four bytes, bits 31:24 first, using polynomial 0x1021 MSB-first with no final XOR. Once busy is low, the CRC register shows every stored word folded in.
- R7: The busy bit (command register bit 8) reads 1 for exactly the 4 cycles that follow an accepted store.
- R8: A command written while busy is 1 has no effect. It causes no store, no CRC clear and no address change.
- R9: Command bit 12 clears the CRC to 0. If it is set together with execute and write, the clear happens first and the new word is then folded into the cleared CRC.
- R10: Execute without the write bit stores nothing, leaves the CRC and address unchanged, and does not raise busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 16 | Host register address |
| host_wdata | input | 16 | Host register write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| mem_we_o | output | 1 | Processor memory write strobe |
| mem_addr_o | output | 32 | Memory byte address (word aligned) |
| mem_wdata_o | output | 32 | Memory write data |

## Verification
A CRC clear and a word store can land on the same clock edge when one command word carries bits 15, 14 and 12 together. The bench first builds up a nonzero CRC and then issues that combined command. The read-back must equal the CRC of the new word alone starting from zero: a clear that lands after the fold, or that is skipped, gives a different value. A second overlap is a command written in the first busy cycle right after a store. The bench judges it by the strobe count, the next address and the CRC, which must all reflect only the first store.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_FOLD = 1'b1
    } mbox_state_t;

    localparam int OFF_CMD   = 0;
    localparam int OFF_CRC   = 1;
    localparam int OFF_ADRHI = 2;
    localparam int OFF_ADRLO = 3;
    localparam int OFF_DATHI = 4;
    localparam int OFF_DATLO = 5;

    localparam int BIT_EXEC  = 15;
    localparam int BIT_WRITE = 14;
    localparam int BIT_CLEAR = 12;
    localparam int BIT_BUSY  = 8;

    // one byte into a non-reflected CRC-16, MSB first
    function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                               input logic [7:0]  b,
                                               input logic [15:0] poly);
        logic [15:0] c;
        logic        fb;
        c = cur;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ b[i];
            c  = {c[14:0], 1'b0} ^ (fb ? poly : 16'h0000);
        end
        return c;
    endfunction

endpackage

// File: rtl/mbox_regs.sv
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int          AW   = 16,
    parameter logic [15:0] BASE = 16'h0200
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [15:0]   host_wdata,
    input  logic          advance,
    output logic [15:0]   addr_hi,
    output logic [15:0]   addr_lo,
    output logic [15:0]   data_hi,
    output logic [15:0]   data_lo
);
    localparam logic [AW-1:0] A_ADRHI = AW'(BASE + OFF_ADRHI);
    localparam logic [AW-1:0] A_ADRLO = AW'(BASE + OFF_ADRLO);
    localparam logic [AW-1:0] A_DATHI = AW'(BASE + OFF_DATHI);
    localparam logic [AW-1:0] A_DATLO = AW'(BASE + OFF_DATLO);

    logic [15:0] hi_q;
    logic [13:0] lo_q;
    logic [29:0] word_next;

    assign word_next = {hi_q, lo_q} + 30'd1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            data_hi <= '0;
            data_lo <= '0;
        end else begin
            if (advance) begin
                hi_q <= word_next[29:14];
                lo_q <= word_next[13:0];
            end else if (host_we && host_addr == A_ADRHI) begin
                hi_q <= host_wdata;
            end else if (host_we && host_addr == A_ADRLO) begin
                lo_q <= host_wdata[15:2];
            end
            if (host_we && host_addr == A_DATHI) data_hi <= host_wdata;
            if (host_we && host_addr == A_DATLO) data_lo <= host_wdata;
        end
    end

    assign addr_hi = hi_q;
    assign addr_lo = {lo_q, 2'b00};

endmodule

// File: rtl/mbox_crc16.sv
module mbox_crc16
    import mbox_pkg::*;
#(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        load,
    input  logic [31:0] word,
    input  logic        fold_en,
    input  logic [1:0]  byte_sel,
    output logic [15:0] crc
);
    logic [31:0] word_q;
    logic [7:0]  cur_byte;

    always_comb begin
        unique case (byte_sel)
            2'd3:    cur_byte = word_q[31:24];
            2'd2:    cur_byte = word_q[23:16];
            2'd1:    cur_byte = word_q[15:8];
            default: cur_byte = word_q[7:0];
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc    <= '0;
            word_q <= '0;
        end else begin
            if (load) word_q <= word;
            if (clear)        crc <= '0;
            else if (fold_en) crc <= crc16_step(crc, cur_byte, POLY);
        end
    end

endmodule

// File: rtl/mbox_fsm.sv
module mbox_fsm
    import mbox_pkg::*;
#(
    parameter int NBYTES = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_hit,
    input  logic       cmd_exec,
    input  logic       cmd_write,
    input  logic       cmd_clear,
    output logic       accept,
    output logic       crc_clear,
    output logic       busy,
    output logic       fold_en,
    output logic [1:0] byte_sel
);
    localparam int CW = $clog2(NBYTES);

    mbox_state_t   state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next state
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (cmd_hit && cmd_exec && cmd_write) begin
                    state_nx = ST_FOLD;
                    cnt_nx   = '0;
                end
            end
            ST_FOLD: begin
                if (cnt == CW'(NBYTES - 1)) begin
                    state_nx = ST_IDLE;
                end
                cnt_nx = cnt + 1'b1;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        accept    = 1'b0;
        crc_clear = 1'b0;
        busy      = 1'b0;
        fold_en   = 1'b0;
        byte_sel  = 2'(NBYTES - 1 - int'(cnt));
        unique case (state)
            ST_IDLE: begin
                accept    = cmd_hit && cmd_exec && cmd_write;
                crc_clear = cmd_hit && cmd_clear;
            end
            ST_FOLD: begin
                busy    = 1'b1;
                fold_en = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mbox_crc_writer.sv
module mbox_crc_writer
    import mbox_pkg::*;
#(
    parameter int          AW   = 16,
    parameter logic [15:0] BASE = 16'h0200,
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [15:0]   host_wdata,
    output logic [15:0]   host_rdata,
    output logic          mem_we_o,
    output logic [31:0]   mem_addr_o,
    output logic [31:0]   mem_wdata_o
);
    localparam logic [AW-1:0] A_CMD   = AW'(BASE + OFF_CMD);
    localparam logic [AW-1:0] A_CRC   = AW'(BASE + OFF_CRC);
    localparam logic [AW-1:0] A_ADRHI = AW'(BASE + OFF_ADRHI);
    localparam logic [AW-1:0] A_ADRLO = AW'(BASE + OFF_ADRLO);
    localparam logic [AW-1:0] A_DATHI = AW'(BASE + OFF_DATHI);
    localparam logic [AW-1:0] A_DATLO = AW'(BASE + OFF_DATLO);

    logic [15:0] addr_hi, addr_lo, data_hi, data_lo;
    logic [15:0] crc;
    logic        cmd_hit, accept, crc_clear, busy, fold_en;
    logic [1:0]  byte_sel;

    assign cmd_hit = host_we && (host_addr == A_CMD);

    mbox_regs #(.AW(AW), .BASE(BASE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .advance    (accept),
        .addr_hi    (addr_hi),
        .addr_lo    (addr_lo),
        .data_hi    (data_hi),
        .data_lo    (data_lo)
    );

    mbox_fsm #(.NBYTES(4)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_hit   (cmd_hit),
        .cmd_exec  (host_wdata[BIT_EXEC]),
        .cmd_write (host_wdata[BIT_WRITE]),
        .cmd_clear (host_wdata[BIT_CLEAR]),
        .accept    (accept),
        .crc_clear (crc_clear),
        .busy      (busy),
        .fold_en   (fold_en),
        .byte_sel  (byte_sel)
    );

    mbox_crc16 #(.POLY(POLY)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (crc_clear),
        .load     (accept),
        .word     ({data_hi, data_lo}),
        .fold_en  (fold_en),
        .byte_sel (byte_sel),
        .crc      (crc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_we_o    <= 1'b0;
            mem_addr_o  <= '0;
            mem_wdata_o <= '0;
        end else begin
            mem_we_o <= accept;
            if (accept) begin
                mem_addr_o  <= {addr_hi, addr_lo};
                mem_wdata_o <= {data_hi, data_lo};
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            A_CMD:   host_rdata[BIT_BUSY] = busy;
            A_CRC:   host_rdata = crc;
            A_ADRHI: host_rdata = addr_hi;
            A_ADRLO: host_rdata = addr_lo;
            A_DATHI: host_rdata = data_hi;
            A_DATLO: host_rdata = data_lo;
            default: host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mbox_writer_chk.sv
module mbox_writer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        mem_we,
    input logic [31:0] mem_addr
);
    logic [2:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             run_len <= '0;
        else if (!busy)         run_len <= '0;
        else if (run_len != 3'd7) run_len <= run_len + 3'd1;
    end

    // R4
    store_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R4
    store_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[1:0] == 2'b00);

    // R7
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_len == 3'd4);

    // R7
    busy_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len < 3'd4);

    // R8
    store_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $rose(busy));

endmodule

bind mbox_crc_writer mbox_writer_chk chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .mem_we   (mem_we_o),
    .mem_addr (mem_addr_o)
);

// File: tb/tb_mbox_crc_writer.sv
`timescale 1ns/100ps
module tb_mbox_crc_writer;
    localparam logic [15:0] A_CMD = 16'h0200, A_CRC = 16'h0201, A_AHI = 16'h0202,
                            A_ALO = 16'h0203, A_DHI = 16'h0204, A_DLO = 16'h0205;

    logic        clk = 0, rst_n = 0, host_we = 0;
    logic [15:0] host_addr = 0, host_wdata = 0, host_rdata;
    logic        mem_we;
    logic [31:0] mem_addr, mem_wdata;
    int total = 0, bad = 0, stores = 0;
    logic [31:0] last_addr, last_data;
    logic [15:0] ref_crc;

    always #2 clk = ~clk;

    mbox_crc_writer dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
    );

    always @(posedge clk) if (rst_n && mem_we) begin
        stores++;
        last_addr = mem_addr;
        last_data = mem_wdata;
    end

    function automatic logic [15:0] ref_fold(input logic [15:0] c0, input logic [31:0] w);
        logic [15:0] c = c0;
        for (int k = 31; k >= 0; k--) begin
            logic f = c[15] ^ w[k];
            c = {c[14:0], 1'b0};
            if (f) c = c ^ 16'h1021;
        end
        return c;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic hr(input logic [15:0] a, output logic [15:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic store(input logic [31:0] w);
        hw(A_DHI, w[31:16]);
        hw(A_DLO, w[15:0]);
        hw(A_CMD, 16'hC000);
        settle();
        ref_crc = ref_fold(ref_crc, w);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        hr(A_CRC, v); check("R1 crc", v, 0);
        hr(A_AHI, v); check("R1 addr hi", v, 0);
        hr(A_ALO, v); check("R1 addr lo", v, 0);
        hr(A_CMD, v); check("R1 busy", v, 0);
        check("R1 mem_we", mem_we, 0);
    endtask

    task automatic t_regmap();
        logic [15:0] v;
        hw(A_DHI, 16'hA5A5); hw(A_DLO, 16'h3C3C);
        hr(A_DHI, v); check("R2 data hi", v, 16'hA5A5);
        hr(A_DLO, v); check("R2 data lo", v, 16'h3C3C);
        hw(A_AHI, 16'h1234); hr(A_AHI, v); check("R2 addr hi", v, 16'h1234);
        hw(A_ALO, 16'hFFFF); hr(A_ALO, v); check("R3 low bits dropped", v, 16'hFFFC);
        hw(16'h0206, 16'hFFFF); hr(16'h0206, v); check("R2 unmapped", v, 0);
        hr(A_DLO, v); check("R2 unmapped write ignored", v, 16'h3C3C);
    endtask

    task automatic t_stream();
        logic [15:0] v;
        int s0;
        hw(A_CMD, 16'h1000); ref_crc = 0;
        hw(A_AHI, 16'h0000); hw(A_ALO, 16'h0010);
        hw(A_DHI, 16'hDEAD); hw(A_DLO, 16'hBEEF);
        s0 = stores;
        hw(A_CMD, 16'hC000);
        check("R4 strobe", mem_we, 1);
        check("R4 addr", mem_addr, 32'h0000_0010);
        check("R4 data", mem_wdata, 32'hDEAD_BEEF);
        for (int i = 0; i < 4; i++) begin
            hr(A_CMD, v); check("R7 busy high", v, 16'h0100);
            @(negedge clk);
        end
        hr(A_CMD, v); check("R7 busy low", v, 0);
        check("R4 single strobe", stores - s0, 1);
        ref_crc = ref_fold(ref_crc, 32'hDEAD_BEEF);
        store(32'h0102_0304);
        check("R5 next addr", last_addr, 32'h0000_0014);
        store(32'hFFFF_0000);
        check("R4 last data", last_data, 32'hFFFF_0000);
        hr(A_ALO, v); check("R5 addr lo", v, 16'h001C);
        hr(A_CRC, v); check("R6 crc three words", v, ref_crc);
    endtask

    task automatic t_carry();
        logic [15:0] v;
        hw(A_AHI, 16'h0001); hw(A_ALO, 16'hFFFC);
        store(32'h5555_AAAA);
        check("R5 carry addr used", last_addr, 32'h0001_FFFC);
        hr(A_ALO, v); check("R5 lo wraps", v, 0);
        hr(A_AHI, v); check("R5 hi carried", v, 16'h0002);
        hr(A_CRC, v); check("R6 crc after carry", v, ref_crc);
    endtask

    task automatic t_busy_ignore();
        logic [15:0] v;
        int s0 = stores;
        hw(A_AHI, 16'h0000); hw(A_ALO, 16'h0040);
        hw(A_DHI, 16'h0F0F); hw(A_DLO, 16'hF0F0);
        hw(A_CMD, 16'hC000);
        hw(A_CMD, 16'hD000);
        settle();
        ref_crc = ref_fold(ref_crc, 32'h0F0F_F0F0);
        check("R8 one store only", stores - s0, 1);
        hr(A_ALO, v); check("R8 addr advanced once", v, 16'h0044);
        hr(A_CRC, v); check("R8 crc not cleared", v, ref_crc);
    endtask

    task automatic t_clear_exec();
        logic [15:0] v;
        hw(A_DHI, 16'h1357); hw(A_DLO, 16'h9BDF);
        hw(A_CMD, 16'hD000);
        settle();
        ref_crc = ref_fold(16'h0, 32'h1357_9BDF);
        hr(A_CRC, v); check("R9 clear then fold", v, ref_crc);
        hw(A_CMD, 16'h1000);
        hr(A_CRC, v); check("R9 clear alone", v, 0);
        ref_crc = 0;
    endtask

    task automatic t_exec_only();
        logic [15:0] v, a0, c0;
        int s0;
        store(32'h2468_ACE0);
        s0 = stores;
        hr(A_ALO, a0); hr(A_CRC, c0);
        hw(A_CMD, 16'h8000);
        hr(A_CMD, v); check("R10 no busy", v, 0);
        settle();
        check("R10 no store", stores - s0, 0);
        hr(A_ALO, v); check("R10 addr same", v, a0);
        hr(A_CRC, v); check("R10 crc same", v, c0);
    endtask

    initial begin
        fork
            begin
                ref_crc = 0;
                repeat (3) @(negedge clk);
                rst_n = 1;
                @(negedge clk);
                t_reset();
                t_regmap();
                t_stream();
                t_carry();
                t_busy_ignore();
                t_clear_exec();
                t_exec_only();
            end
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule